// File: doc/BRIEF.md
# Time-Quantized Pulse-Width Digitizer

This block turns a pulse-width-modulated input into two binary numbers per frame, and it rebuilds the pulse with its edges moved onto a fixed time grid. A frame has `NPHASE` equal time steps. In this synthesizable form, one cycle of a fast tick clock stands for each step, and a phase counter marks where each frame starts and ends. At every step a dedicated sampler latches the input. Together the samplers hold a thermometer picture of the pulse. At the end of the frame an encoder reduces that picture to a rising-edge step index and a falling-edge step index.

The same samples drive a set/clear latch that produces the quantized pulse. This pulse goes high on the grid step that first finds the input high. It goes low on the first later step that finds the input low. Both the codes and the regenerated pulse come from the same sampled values, so the width of the regenerated pulse always equals the difference between the two codes. The regenerated pulse is meant to be used as the feedback signal of a noise-shaping converter loop.

Top module: `tq_pwm_digitizer`

## Requirements
- R1: While `rstN` is low, `pulseQ`, `codeValid`, `riseCode` and `fallCode` are all 0.
- R2: The first tick edge after reset is step 0 of a frame, and each frame is `NPHASE` ticks long. `codeValid` is high for exactly one tick per frame: the tick that follows the edge sampling the frame's last step.
- R3: `riseCode` is the index of the first step in the frame (steps counted from 0) whose sample of `pwmIn` is 1. It is `NPHASE` if no step samples 1.
- R4: `fallCode` is the index of the first step after the rising step whose sample is 0. It is `NPHASE` if the input stays high to the end of the frame, or if there is no rising step.
- R5: `pulseQ` goes high on the same tick edge that samples the rising step, so it is high in the tick that follows that edge. It never rises unless the input was sampled high on that edge.
- R6: `pulseQ` goes low on the edge that samples the falling step. Any further high samples later in the same frame have no effect on `pulseQ` or on the codes.
- R7: If `pulseQ` is still high at the end of a frame, it goes low on the first edge of the next frame, unless that edge samples the input high. In that case it stays high without a gap.
- R8: Within every frame, the number of ticks for which `pulseQ` is high equals `fallCode - riseCode`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock; one cycle per time step |
| rstN | input | 1 | Active-low synchronous reset |
| pwmIn | input | 1 | Pulse-width-modulated input |
| riseCode | output | $clog2(NPHASE+1) | Step index of the rising edge, or NPHASE |
| fallCode | output | $clog2(NPHASE+1) | Step index of the falling edge, or NPHASE |
| codeValid | output | 1 | One-tick strobe when the codes are updated |
| pulseQ | output | 1 | Grid-aligned regenerated pulse |

## Verification
The set/clear state is cleared only at frame boundaries. If it is wrong, a second pulse within one frame re-arms `pulseQ`. The per-frame high-tick count then departs from `fallCode - riseCode` in that same frame. A stale sampler bit or a wrong encoder loop corrupts the codes, and this shows on the single `codeValid` tick at the end of the frame. A phase counter that slips moves that strobe away from the `NPHASE`-tick spacing, and the first frame after reset already shows this. The bench drives frames with no edge, a full-width pulse, pulses at either boundary, a double pulse and random widths, so each of these faults surfaces within one frame.

// File: rtl/tq_pkg.sv
package tq_pkg;
  // Strobes sent from the frame sequencer to the sampling datapath
  typedef struct packed {
    logic frameStart;  // current tick samples step 0
    logic frameEnd;    // current tick samples the last step
  } tqStrobe_t;
endpackage

// File: rtl/tq_frame_ctrl.sv
module tq_frame_ctrl
  import tq_pkg::*;
#(
  parameter int NPHASE = 8,
  localparam int PW = $clog2(NPHASE)
) (
  input  logic          clk,
  input  logic          rstN,
  output tqStrobe_t     strobe,
  output logic [PW-1:0] phase
);
  localparam logic [PW-1:0] LAST = PW'(NPHASE - 1);

  always_ff @(posedge clk) begin
    if (!rstN)              phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  always_comb begin
    strobe.frameStart = (phase == '0);
    strobe.frameEnd   = (phase == LAST);
  end

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    phase <= LAST);
  // R2
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == LAST) |=> (phase == '0));
endmodule

// File: rtl/tq_sample_path.sv
module tq_sample_path
  import tq_pkg::*;
#(
  parameter int NPHASE = 8,
  localparam int PW = $clog2(NPHASE),
  localparam int CW = $clog2(NPHASE + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pwmIn,
  input  tqStrobe_t     strobe,
  input  logic [PW-1:0] phase,
  output logic [CW-1:0] riseCode,
  output logic [CW-1:0] fallCode,
  output logic          codeValid,
  output logic          pulseQ
);
  localparam logic [CW-1:0] NONE = CW'(NPHASE);

  logic [NPHASE-1:0] therm;
  logic [NPHASE-1:0] curVec;
  logic [CW-1:0]     riseIdx, fallIdx;
  logic              seenHigh;
  logic              risenQ, fallenQ, risen, fallen, setQ, clrQ;

  // One sampler per step; cleared at the start of each frame
  for (genvar i = 0; i < NPHASE; i++) begin : gSampler
    always_ff @(posedge clk) begin
      if (!rstN)                       therm[i] <= 1'b0;
      else if (phase == PW'(i))        therm[i] <= pwmIn;
      else if (strobe.frameStart)      therm[i] <= 1'b0;
    end
  end

  // Thermometer picture including the sample taken on this edge
  always_comb begin
    curVec        = therm;
    curVec[phase] = pwmIn;
  end

  // Thermometer-to-index encoders
  always_comb begin
    riseIdx  = NONE;
    for (int i = NPHASE - 1; i >= 0; i--)
      if (curVec[i]) riseIdx = CW'(i);
    fallIdx  = NONE;
    seenHigh = 1'b0;
    for (int i = 0; i < NPHASE; i++) begin
      if (curVec[i])                          seenHigh = 1'b1;
      else if (seenHigh && fallIdx == NONE)   fallIdx  = CW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      riseCode  <= '0;
      fallCode  <= '0;
      codeValid <= 1'b0;
    end else begin
      codeValid <= strobe.frameEnd;
      if (strobe.frameEnd) begin
        riseCode <= riseIdx;
        fallCode <= fallIdx;
      end
    end
  end

  // Set/clear latch for the grid-aligned pulse
  always_comb begin
    risen  = strobe.frameStart ? 1'b0 : risenQ;
    fallen = strobe.frameStart ? 1'b0 : fallenQ;
    setQ   = !risen && pwmIn;
    clrQ   = risen && !fallen && !pwmIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      risenQ  <= 1'b0;
      fallenQ <= 1'b0;
      pulseQ  <= 1'b0;
    end else begin
      risenQ  <= risen | setQ;
      fallenQ <= fallen | clrQ;
      if (setQ)                   pulseQ <= 1'b1;
      else if (clrQ)              pulseQ <= 1'b0;
      else if (strobe.frameStart) pulseQ <= 1'b0;
    end
  end

  // R5
  rise_on_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseQ) |-> $past(pwmIn));
  // R6
  fall_on_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pulseQ) |-> !$past(pwmIn));
  // R2
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |=> !codeValid);
  // R4
  code_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |-> (riseCode <= fallCode && fallCode <= NONE));
  // R6
  no_rearm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fallenQ && !strobe.frameStart) |=> !$rose(pulseQ));
endmodule

// File: rtl/tq_pwm_digitizer.sv
module tq_pwm_digitizer
  import tq_pkg::*;
#(
  parameter int NPHASE = 8,
  localparam int PW = $clog2(NPHASE),
  localparam int CW = $clog2(NPHASE + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pwmIn,
  output logic [CW-1:0] riseCode,
  output logic [CW-1:0] fallCode,
  output logic          codeValid,
  output logic          pulseQ
);
  tqStrobe_t     strobe;
  logic [PW-1:0] phase;

  tq_frame_ctrl #(.NPHASE(NPHASE)) uCtrl (
    .clk(clk), .rstN(rstN), .strobe(strobe), .phase(phase)
  );

  tq_sample_path #(.NPHASE(NPHASE)) uPath (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .strobe(strobe), .phase(phase),
    .riseCode(riseCode), .fallCode(fallCode), .codeValid(codeValid),
    .pulseQ(pulseQ)
  );
endmodule

// File: tb/sim_tq_pwm_digitizer.sv
module sim_tq_pwm_digitizer;
  localparam int N  = 8;
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          pwmIn = 1'b0;
  logic [CW-1:0] riseCode, fallCode;
  logic          codeValid, pulseQ;
  int            nChecks = 0;
  int            nErrors = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  tq_pwm_digitizer #(.NPHASE(N)) u0 (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .riseCode(riseCode),
    .fallCode(fallCode), .codeValid(codeValid), .pulseQ(pulseQ)
  );

  // Each row: high interval [a,b), second interval [c,d), expected rise, expected fall
  localparam int VEC [10][6] = '{
    '{2, 5, 0, 0, 2, 5},
    '{0, 0, 0, 0, 8, 8},
    '{0, 8, 0, 0, 0, 8},
    '{0, 8, 0, 0, 0, 8},
    '{0, 1, 0, 0, 0, 1},
    '{7, 8, 0, 0, 7, 8},
    '{1, 3, 5, 7, 1, 3},
    '{3, 4, 6, 8, 3, 4},
    '{5, 8, 0, 0, 5, 8},
    '{0, 2, 4, 5, 0, 2}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Runs one frame starting just before the step-0 edge
  task automatic runFrame(input int a, input int b, input int c, input int d,
                          input int eRise, input int eFall);
    int highCnt = 0;
    int validCnt = 0;
    for (int p = 0; p < N; p++) begin
      pwmIn = (p >= a && p < b) || (p >= c && p < d);
      @(posedge clk);
      @(negedge clk);
      if (pulseQ) highCnt++;
      if (codeValid) validCnt++;
      if (p == N - 1) begin
        chk(codeValid == 1'b1, "R2 valid at frame end", int'(codeValid), 1);
        chk(int'(riseCode) == eRise, "R3 riseCode", int'(riseCode), eRise);
        chk(int'(fallCode) == eFall, "R4 R6 fallCode", int'(fallCode), eFall);
      end
    end
    chk(validCnt == 1, "R2 one strobe per frame", validCnt, 1);
    chk(highCnt == eFall - eRise, "R8 pulse width vs codes", highCnt, eFall - eRise);
  endtask

  initial begin
    #2000000;
    nErrors++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk(pulseQ == 1'b0, "R1 pulseQ in reset", int'(pulseQ), 0);
    chk(codeValid == 1'b0, "R1 codeValid in reset", int'(codeValid), 0);
    chk(riseCode == '0 && fallCode == '0, "R1 codes in reset",
        int'(riseCode) + int'(fallCode), 0);
    rstN = 1'b1;

    foreach (VEC[k]) runFrame(VEC[k][0], VEC[k][1], VEC[k][2], VEC[k][3],
                              VEC[k][4], VEC[k][5]);

    // R5 exact rise edge: input high from step 4
    pwmIn = 1'b0;
    for (int p = 0; p < N; p++) begin
      pwmIn = (p >= 4);
      @(posedge clk);
      @(negedge clk);
      if (p == 3) chk(pulseQ == 1'b0, "R5 low before rising step", int'(pulseQ), 0);
      if (p == 4) chk(pulseQ == 1'b1, "R5 high after rising step", int'(pulseQ), 1);
    end
    // R7 previous frame ended high; input low at step 0 clears pulse
    pwmIn = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(pulseQ == 1'b0, "R7 boundary fall", int'(pulseQ), 0);
    for (int p = 1; p < N; p++) begin
      pwmIn = 1'b0;
      @(posedge clk);
      @(negedge clk);
    end
    chk(int'(riseCode) == N && int'(fallCode) == N, "R3 R4 empty frame",
        int'(riseCode) * 16 + int'(fallCode), N * 16 + N);

    // Random widths
    for (int k = 0; k < 40; k++) begin
      int r = $urandom_range(0, N);
      int f = $urandom_range(r, N);
      runFrame(r, f, 0, 0, (r == f) ? N : r, (r == f) ? N : f);
    end

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule